// File: doc/BRIEF.md
# UART Interrupt Enable, Mask and Status Controller

This block keeps the interrupt register set of a serial port as a memory-mapped slave on a plain write-strobe bus with combinational read data. Software never writes the interrupt mask directly. It writes ones to an arm register to set mask bits, or ones to a disarm register to clear them, and it reads the resulting mask at its own read-only offset. Event pulses and level conditions from the receive and transmit paths latch into a sticky status register. Software clears that register by writing ones to it.

A separate channel status word shows the live level conditions whatever the mask holds. A polling routine can therefore watch FIFO state without taking interrupts. The single interrupt output is high whenever a latched status bit is also unmasked.

Top module: `uirq_ctrl`

## Requirements
- R1: A write at offset 0x08 sets every mask bit whose write-data bit is 1 and leaves the other mask bits as they were, from the clock edge of the write.
- R2: A write at offset 0x0C clears every mask bit whose write-data bit is 1 and leaves the other mask bits as they were, from the clock edge of the write.
- R3: Reads at 0x08 and 0x0C return zero. The mask reads at 0x10, and writes at 0x10 leave it unchanged.
- R4: Interrupt bit positions are fixed: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout. An event pulse on source i sets status bit i at the next clock edge. For bits 0 to 4 a high level condition does the same.
- R5: Status bits stay set until a 1 is written to the same bit at offset 0x14. If a set and a clear of one bit fall in the same cycle, the bit stays set.
- R6: A read at 0x2C returns the live receive trigger, receive empty, transmit empty and transmit full conditions at bits 0, 1, 3 and 4, whatever the mask holds. All other bits of that word read 0.
- R7: The interrupt output is high exactly when some status bit and the mask bit at the same position are both 1.
- R8: Only bits 12:0 of the mask and status hold state. Higher write-data bits have no effect, higher read bits are 0, and reads at unmapped offsets return 0.
- R9: An active-low reset clears the mask and the status, so the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_evt | input | 9 | Event pulses, one per interrupt bit 0 to 8 |
| live_cond | input | 5 | Level conditions for bits 0 to 4 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench clears a status bit while its level source is still high. A design that let the clear win would drop the bit and lower the interrupt while the condition still holds. It also lands an event and a clearing write on the same bit in one cycle, which catches a design that gives the clear priority.

The bench writes at the read-only mask offset and writes all-ones words. These catch a mask that takes direct writes or keeps bits above 12. It disarms a bit whose status is still set, to show that the status survives while the interrupt falls; a design that tied status to the mask would fail this. It drives the receive-full level and checks that bit 2 of the channel word stays 0, which catches a channel word that exposes the wrong conditions.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int unsigned UIRQ_ADDR_W = 8;
    localparam int unsigned UIRQ_DATA_W = 32;
    localparam int unsigned UIRQ_FIELD_W = 13;
    localparam int unsigned UIRQ_NSRC = 9;
    localparam int unsigned UIRQ_NLIVE = 5;

    localparam logic [UIRQ_ADDR_W-1:0] OFS_ARM = 8'h08;
    localparam logic [UIRQ_ADDR_W-1:0] OFS_DISARM = 8'h0C;
    localparam logic [UIRQ_ADDR_W-1:0] OFS_MASK = 8'h10;
    localparam logic [UIRQ_ADDR_W-1:0] OFS_STAT = 8'h14;
    localparam logic [UIRQ_ADDR_W-1:0] OFS_CHAN = 8'h2C;

    localparam int unsigned BIT_RX_TRIG = 0;
    localparam int unsigned BIT_RX_EMPTY = 1;
    localparam int unsigned BIT_RX_FULL = 2;
    localparam int unsigned BIT_TX_EMPTY = 3;
    localparam int unsigned BIT_TX_FULL = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ZERO,
        SEL_MASK,
        SEL_STAT,
        SEL_CHAN
    } rd_sel_e;

    function automatic rd_sel_e decode_rd(input logic [UIRQ_ADDR_W-1:0] a);
        rd_sel_e s;
        unique case (a)
            OFS_ARM, OFS_DISARM: s = SEL_ZERO;
            OFS_MASK: s = SEL_MASK;
            OFS_STAT: s = SEL_STAT;
            OFS_CHAN: s = SEL_CHAN;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
    import uirq_pkg::*;
#(
    parameter int unsigned ADDR_W = UIRQ_ADDR_W,
    parameter int unsigned DATA_W = UIRQ_DATA_W,
    parameter int unsigned FIELD_W = UIRQ_FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FIELD_W-1:0] mask
);

    typedef struct packed {
        logic [FIELD_W-1:0] bits;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic [FIELD_W-1:0] wfield;

    assign wfield = wdata[FIELD_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr && addr == ADDR_W'(OFS_ARM)) begin
            st_d.bits = st_q.bits | wfield;
        end else if (wr && addr == ADDR_W'(OFS_DISARM)) begin
            st_d.bits = st_q.bits & ~wfield;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.bits;

endmodule

// File: rtl/uirq_status_reg.sv
module uirq_status_reg
    import uirq_pkg::*;
#(
    parameter int unsigned ADDR_W = UIRQ_ADDR_W,
    parameter int unsigned DATA_W = UIRQ_DATA_W,
    parameter int unsigned FIELD_W = UIRQ_FIELD_W,
    parameter int unsigned NSRC = UIRQ_NSRC,
    parameter int unsigned NLIVE = UIRQ_NLIVE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NSRC-1:0]    src_evt,
    input  logic [NLIVE-1:0]   live_cond,
    output logic [FIELD_W-1:0] status
);

    typedef struct packed {
        logic [FIELD_W-1:0] bits;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [FIELD_W-1:0] set_vec;
    logic [FIELD_W-1:0] clr_vec;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_set
        if (i < NLIVE && i < NSRC) begin : g_lvl
            assign set_vec[i] = src_evt[i] | live_cond[i];
        end else if (i < NSRC) begin : g_evt
            assign set_vec[i] = src_evt[i];
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    assign clr_vec = (wr && addr == ADDR_W'(OFS_STAT)) ? wdata[FIELD_W-1:0] : '0;

    always_comb begin
        st_d = st_q;
        st_d.bits = (st_q.bits & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.bits;

endmodule

// File: rtl/uirq_read_mux.sv
module uirq_read_mux
    import uirq_pkg::*;
#(
    parameter int unsigned ADDR_W = UIRQ_ADDR_W,
    parameter int unsigned DATA_W = UIRQ_DATA_W,
    parameter int unsigned FIELD_W = UIRQ_FIELD_W,
    parameter int unsigned NLIVE = UIRQ_NLIVE
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] status,
    input  logic [NLIVE-1:0]   live_cond,
    output logic [DATA_W-1:0]  rdata
);

    localparam logic [NLIVE-1:0] CHAN_KEEP =
        NLIVE'((1 << BIT_RX_TRIG) | (1 << BIT_RX_EMPTY) |
               (1 << BIT_TX_EMPTY) | (1 << BIT_TX_FULL));

    logic [FIELD_W-1:0] chan;

    assign chan = FIELD_W'(live_cond & CHAN_KEEP);

    always_comb begin
        rdata = '0;
        unique case (decode_rd(UIRQ_ADDR_W'(addr)))
            SEL_MASK: rdata = DATA_W'(mask);
            SEL_STAT: rdata = DATA_W'(status);
            SEL_CHAN: rdata = DATA_W'(chan);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int unsigned ADDR_W = UIRQ_ADDR_W,
    parameter int unsigned DATA_W = UIRQ_DATA_W,
    parameter int unsigned FIELD_W = UIRQ_FIELD_W,
    parameter int unsigned NSRC = UIRQ_NSRC,
    parameter int unsigned NLIVE = UIRQ_NLIVE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_evt,
    input  logic [NLIVE-1:0]  live_cond,
    output logic              irq_o
);

    logic [FIELD_W-1:0] mask_q;
    logic [FIELD_W-1:0] status_q;

    uirq_mask_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FIELD_W(FIELD_W)
    ) u_mask (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (bus_wr),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .mask (mask_q)
    );

    uirq_status_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FIELD_W(FIELD_W),
        .NSRC   (NSRC),
        .NLIVE  (NLIVE)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .src_evt  (src_evt),
        .live_cond(live_cond),
        .status   (status_q)
    );

    uirq_read_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FIELD_W(FIELD_W),
        .NLIVE  (NLIVE)
    ) u_rd (
        .addr     (bus_addr),
        .mask     (mask_q),
        .status   (status_q),
        .live_cond(live_cond),
        .rdata    (bus_rdata)
    );

    assign irq_o = |(status_q & mask_q);

endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk
    import uirq_pkg::*;
#(
    parameter int unsigned ADDR_W = UIRQ_ADDR_W,
    parameter int unsigned DATA_W = UIRQ_DATA_W,
    parameter int unsigned FIELD_W = UIRQ_FIELD_W,
    parameter int unsigned NSRC = UIRQ_NSRC,
    parameter int unsigned NLIVE = UIRQ_NLIVE
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NSRC-1:0]    src_evt,
    input logic               irq_o,
    input logic [FIELD_W-1:0] mask_q,
    input logic [FIELD_W-1:0] status_q
);

    logic arm_wr, disarm_wr, stat_wr;
    assign arm_wr = bus_wr && bus_addr == ADDR_W'(OFS_ARM);
    assign disarm_wr = bus_wr && bus_addr == ADDR_W'(OFS_DISARM);
    assign stat_wr = bus_wr && bus_addr == ADDR_W'(OFS_STAT);

    p_arm_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (mask_q & $past(bus_wdata[FIELD_W-1:0])) == $past(bus_wdata[FIELD_W-1:0]));

    p_disarm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_wr |=> (mask_q & $past(bus_wdata[FIELD_W-1:0])) == '0);

    p_mask_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm_wr || disarm_wr) |=> $stable(mask_q));

    p_evt_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> (status_q[NSRC-1:0] & $past(src_evt)) == $past(src_evt));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (status_q & $past(status_q)) == $past(status_q));

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_q != '0 && mask_q != '0));

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:FIELD_W] == '0);

endmodule

bind uirq_ctrl uirq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FIELD_W(FIELD_W),
    .NSRC   (NSRC),
    .NLIVE  (NLIVE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_evt  (src_evt),
    .irq_o    (irq_o),
    .mask_q   (mask_q),
    .status_q (status_q)
);

// File: tb/uirq_ctrl_bench.sv
module uirq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  src_evt = '0;
    logic [4:0]  live_cond = '0;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uirq_ctrl u_uirq_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .src_evt  (src_evt),
        .live_cond(live_cond),
        .irq_o    (irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [8:0]  evt;
        logic [4:0]  live;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h08, 32'h0000_0009, 9'h000, 5'h00, 8'h10, 32'h0000_0009, 1'b0}, // R1
        '{1'b1, 8'h0C, 32'h0000_0001, 9'h000, 5'h00, 8'h10, 32'h0000_0008, 1'b0}, // R2
        '{1'b0, 8'h00, 32'h0000_0000, 9'h020, 5'h00, 8'h14, 32'h0000_0020, 1'b0}, // R4
        '{1'b1, 8'h08, 32'h0000_0020, 9'h000, 5'h00, 8'h14, 32'h0000_0020, 1'b1}, // R7
        '{1'b1, 8'h14, 32'h0000_0020, 9'h000, 5'h00, 8'h14, 32'h0000_0000, 1'b0}, // R5
        '{1'b0, 8'h00, 32'h0000_0000, 9'h000, 5'h08, 8'h2C, 32'h0000_0008, 1'b1}, // R6
        '{1'b1, 8'h14, 32'h0000_0008, 9'h000, 5'h08, 8'h14, 32'h0000_0008, 1'b1}, // R5 level wins
        '{1'b1, 8'h14, 32'h0000_0008, 9'h000, 5'h00, 8'h14, 32'h0000_0000, 1'b0}, // R5
        '{1'b1, 8'h08, 32'h0000_1FFF, 9'h000, 5'h00, 8'h08, 32'h0000_0000, 1'b0}, // R3
        '{1'b0, 8'h00, 32'h0000_0000, 9'h000, 5'h00, 8'h0C, 32'h0000_0000, 1'b0}, // R3
        '{1'b0, 8'h00, 32'h0000_0000, 9'h000, 5'h00, 8'h10, 32'h0000_1FFF, 1'b0}, // R1
        '{1'b1, 8'h10, 32'h0000_0000, 9'h000, 5'h00, 8'h10, 32'h0000_1FFF, 1'b0}, // R3 read-only
        '{1'b1, 8'h08, 32'hFFFF_FFFF, 9'h000, 5'h00, 8'h10, 32'h0000_1FFF, 1'b0}, // R8
        '{1'b0, 8'h00, 32'h0000_0000, 9'h1FF, 5'h00, 8'h14, 32'h0000_01FF, 1'b1}, // R4
        '{1'b1, 8'h14, 32'h0000_01FF, 9'h100, 5'h00, 8'h14, 32'h0000_0100, 1'b1}, // R5 set wins
        '{1'b1, 8'h0C, 32'h0000_0100, 9'h000, 5'h00, 8'h14, 32'h0000_0100, 1'b0}, // R7
        '{1'b0, 8'h00, 32'h0000_0000, 9'h000, 5'h1F, 8'h2C, 32'h0000_001B, 1'b1}, // R6
        '{1'b1, 8'h14, 32'h0000_1FFF, 9'h000, 5'h00, 8'h14, 32'h0000_0000, 1'b0}, // R5
        '{1'b0, 8'h00, 32'h0000_0000, 9'h000, 5'h04, 8'h2C, 32'h0000_0000, 1'b1}, // R6 rx full hidden
        '{1'b0, 8'h00, 32'h0000_0000, 9'h000, 5'h00, 8'h30, 32'h0000_0000, 1'b1}, // R8 unmapped
        '{1'b1, 8'h14, 32'h0000_0004, 9'h000, 5'h00, 8'h14, 32'h0000_0000, 1'b0}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a);
        @(negedge clk);
        bus_wr = 1'b0;
        src_evt = '0;
        bus_addr = a;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        read_at(8'h10);
        check("R9 mask after reset", bus_rdata, 32'h0);
        read_at(8'h14);
        check("R9 status after reset", bus_rdata, 32'h0);
        check("R9 irq after reset", {31'h0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr = VECS[i].wr;
            bus_addr = VECS[i].waddr;
            bus_wdata = VECS[i].wdata;
            src_evt = VECS[i].evt;
            live_cond = VECS[i].live;
            read_at(VECS[i].raddr);
            check($sformatf("vec%0d rdata", i), bus_rdata, VECS[i].exp_rd);
            check($sformatf("vec%0d irq", i), {31'h0, irq_o}, {31'h0, VECS[i].exp_irq});
        end

        // R9: reset mid-run clears mask and latched status
        @(negedge clk);
        bus_wr = 1'b0;
        src_evt = 9'h0C0;
        @(negedge clk);
        src_evt = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_at(8'h10);
        check("R9 mask cleared by reset", bus_rdata, 32'h0);
        read_at(8'h14);
        check("R9 status cleared by reset", bus_rdata, 32'h0);
        check("R9 irq low after reset", {31'h0, irq_o}, 32'h0);

        // R1 and R7: arming after a latched event raises irq
        @(negedge clk);
        src_evt = 9'h040;
        read_at(8'h14);
        check("R4 framing latched", bus_rdata, 32'h0000_0040);
        check("R7 irq low while masked", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = 8'h08;
        bus_wdata = 32'h0000_0040;
        read_at(8'h10);
        check("R1 mask arm bit6", bus_rdata, 32'h0000_0040);
        check("R7 irq high once armed", {31'h0, irq_o}, 32'h1);

        finish_run();
    end

endmodule